// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is a two-stage countdown timer. One copy sits beside each processor core. The first stage is a prescaler. It reloads from a tick-count buffer and emits one tick every (tick count + 1) clock cycles. The second stage counts those ticks down from an interrupt-count buffer. When it expires, it sets a sticky status bit, and that bit drives the interrupt line through an enable mask.

Software reaches the block through a simple 32-bit register bus, with an 8-bit offset inside the block's own 256-byte window. The interrupt counter can run in two ways:

- **One-shot:** the counter fires once and then drops its own run bit.
- **Repeat:** the counter reloads itself and keeps firing until software stops it.

A write to the interrupt-count buffer only takes effect when bit 31 of the written word is set. Every write to the tick buffer, the interrupt-count buffer or the control word raises a sticky write-acknowledge flag. Software polls that flag and then clears it.

Top module: `loc_tick_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Reset may also be applied while the timer is running.
- R2: A write to offset 0x00 loads the tick buffer from the low PRE_W bits, and the tick buffer reads back at 0x00. The write also sets bit 0 of the write-acknowledge word at offset 0x40.
- R3: A write to offset 0x08 loads the interrupt-count buffer from bits [CNT_W-1:0] only when bit 31 of the written word is 1. With bit 31 at 0 the buffer is unchanged. Either kind of write sets bit 1 at 0x40. The buffer reads back at 0x08 with bit 31 reading 0.
- R4: The control word at 0x20 has these bits:
  - bit 0: timer run
  - bit 1: interrupt-counter run
  - bit 2: repeat mode

  The control word reads back at 0x20, and a write to it sets bit 3 at 0x40.
- R5: Each write-acknowledge bit at 0x40 is cleared by writing 1 to that bit. Writing 0 leaves the bit set.
- R6: In one-shot mode, the status bit sets exactly N*(T+1) cycles after the edge that applied a control write which set both run bits from stopped. Here T is the tick buffer and N is the interrupt-count buffer. At the same edge, control bit 1 clears, and no further expiry follows.
- R7: In repeat mode, expiries recur every N*(T+1) cycles from that start edge. A status clear in between does not shift the period.
- R8: The status bit is at offset 0x30, bit 0. It is cleared by writing 1 to it. If an expiry and a clear fall in the same cycle, the expiry wins.
- R9: `irq` is high exactly when the status bit is 1 and the enable bit (offset 0x34, bit 0) is 1.
- R10: While control bit 0 is 0, both counters hold and no expiry occurs. Setting bit 0 again from 0 reloads both counters, so the next expiry comes a full N*(T+1) cycles later.
- R11: A write to an unmapped offset changes no register. A read from an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 8 | Byte offset inside the block window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt, status AND enable |

## Verification
The hardest behaviour to reach from the ports is exact expiry timing. The internal counters cannot be read, so the period has to be measured from the outside. The bench counts clock edges from the edge that applies the start write and watches `irq` each cycle. It expects the rise at exactly N*(T+1) edges, and in repeat mode at twice that, even though a status clear is inserted in between.

Freezing is shown the same way. The bench stops the timer partway through a period, confirms that no expiry appears during a long pause, and then confirms that a restart delivers a whole fresh period rather than the remainder of the old one.

// File: rtl/loc_tick_pkg.sv
package loc_tick_pkg;

  // Register offsets inside the block window
  localparam logic [7:0] OFS_TICK = 8'h00;
  localparam logic [7:0] OFS_ICNT = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_IEN  = 8'h34;
  localparam logic [7:0] OFS_WACK = 8'h40;

  // Bit positions in the write-acknowledge word
  localparam int WACK_TICK = 0;
  localparam int WACK_ICNT = 1;
  localparam int WACK_CTRL = 3;
  localparam int WACK_W    = 4;

  // Update-request bit of an interrupt-count write
  localparam int ICNT_UPD = 31;

  typedef struct packed {
    logic rpt;   // bit 2: repeat mode
    logic irun;  // bit 1: interrupt-counter run
    logic run;   // bit 0: timer run
  } ctrl_t;

endpackage

// File: rtl/loc_tick_rst_sync.sv
module loc_tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // Shift ones in after release; assertion of reset clears the chain at once
  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/loc_tick_presc.sv
module loc_tick_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);

  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic             cnt_en;

  // A tick is emitted on the cycle the counter sits at zero, then it reloads
  always_comb begin
    tick   = run && !load && (cnt_q == '0);
    cnt_en = load || run;
    cnt_d  = cnt_q;
    if (load)                cnt_d = reload;
    else if (cnt_q == '0)    cnt_d = reload;
    else                     cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: a stopped prescaler holds its count
  p_presc_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

  // R6: after a tick the count restarts from the buffer
  p_presc_wrap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/loc_tick_icnt.sv
module loc_tick_icnt #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;
  logic             last;

  // The tick that finds the count at 1 (or 0) is the expiring one
  always_comb begin
    step   = tick && active && !load;
    last   = (cnt_q <= ONE);
    expire = step && last;
    cnt_d  = cnt_q;
    if (load)      cnt_d = reload;
    else if (step) cnt_d = last ? reload : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load || step)  cnt_q <= cnt_d;
  end

  // R6: every tick that does not expire takes exactly one off the count
  p_icnt_step_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (cnt_q == $past(cnt_q) - ONE));

  // R10: without a tick the count holds
  p_icnt_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/loc_tick_regs.sv
module loc_tick_regs
  import loc_tick_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             expire,
  output logic [31:0]      rdata,
  output logic [PRE_W-1:0] tick_buf,
  output logic [CNT_W-1:0] icnt_buf,
  output ctrl_t            ctrl,
  output logic             start_load,
  output logic             icnt_load,
  output logic             irq
);

  logic             wr_tick, wr_icnt, wr_ctrl, wr_stat, wr_ien, wr_wack;
  logic [PRE_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0] icnt_q, icnt_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             stat_q, stat_d;
  logic             ien_q, ien_d;
  logic [WACK_W-1:0] wack_q, wack_d, wack_set;

  always_comb begin
    wr_tick = sel && wr && (addr == OFS_TICK);
    wr_icnt = sel && wr && (addr == OFS_ICNT);
    wr_ctrl = sel && wr && (addr == OFS_CTRL);
    wr_stat = sel && wr && (addr == OFS_STAT);
    wr_ien  = sel && wr && (addr == OFS_IEN);
    wr_wack = sel && wr && (addr == OFS_WACK);
  end

  // Counter reload requests come from run bits rising on a control write
  always_comb begin
    start_load = wr_ctrl && wdata[0] && !ctrl_q.run;
    icnt_load  = start_load || (wr_ctrl && wdata[1] && !ctrl_q.irun);
  end

  // Next-state for the configuration and status registers
  always_comb begin
    tick_d = wr_tick ? wdata[PRE_W-1:0] : tick_q;
    icnt_d = (wr_icnt && wdata[ICNT_UPD]) ? wdata[CNT_W-1:0] : icnt_q;
    ien_d  = wr_ien ? wdata[0] : ien_q;

    ctrl_d = ctrl_q;
    if (wr_ctrl)                      ctrl_d = ctrl_t'(wdata[2:0]);
    else if (expire && !ctrl_q.rpt)   ctrl_d.irun = 1'b0;

    if (expire)                       stat_d = 1'b1;
    else if (wr_stat && wdata[0])     stat_d = 1'b0;
    else                              stat_d = stat_q;
  end

  // Write-acknowledge flags: set by a write to the owning register, W1C
  always_comb begin
    wack_set            = '0;
    wack_set[WACK_TICK] = wr_tick;
    wack_set[WACK_ICNT] = wr_icnt;
    wack_set[WACK_CTRL] = wr_ctrl;
  end

  for (genvar i = 0; i < WACK_W; i++) begin : g_wack
    always_comb begin
      wack_d[i] = wack_set[i] || (wack_q[i] && !(wr_wack && wdata[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      icnt_q <= '0;
      ctrl_q <= '0;
      stat_q <= 1'b0;
      ien_q  <= 1'b0;
      wack_q <= '0;
    end else begin
      tick_q <= tick_d;
      icnt_q <= icnt_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      wack_q <= wack_d;
    end
  end

  // Read mux, zero-extended, unmapped offsets return zero
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_TICK: rdata[PRE_W-1:0]  = tick_q;
      OFS_ICNT: rdata[CNT_W-1:0]  = icnt_q;
      OFS_CTRL: rdata[2:0]        = ctrl_q;
      OFS_STAT: rdata[0]          = stat_q;
      OFS_IEN:  rdata[0]          = ien_q;
      OFS_WACK: rdata[WACK_W-1:0] = wack_q;
      default:  rdata             = '0;
    endcase
  end

  assign tick_buf = tick_q;
  assign icnt_buf = icnt_q;
  assign ctrl     = ctrl_q;
  assign irq      = stat_q && ien_q;

  // R2: a tick-buffer write is acknowledged on the next cycle
  p_wack_tick_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_tick |=> wack_q[WACK_TICK]);

  // R3: an interrupt-count write without the update bit leaves the buffer
  p_icnt_noupd_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icnt && !wdata[ICNT_UPD]) |=> $stable(icnt_q));

  // R8: a clear with no competing expiry drops the status bit
  p_stat_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[0] && !expire) |=> !stat_q);

  // R6: a one-shot expiry drops the interrupt-counter run bit
  p_oneshot_stop_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.rpt && !wr_ctrl) |=> !ctrl_q.irun);

endmodule

// File: rtl/loc_tick_timer.sv
module loc_tick_timer
  import loc_tick_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int CNT_W  = 31,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  logic             rst_n_s;
  logic [PRE_W-1:0] tick_buf;
  logic [CNT_W-1:0] icnt_buf;
  ctrl_t            ctrl;
  logic             start_load;
  logic             icnt_load;
  logic             tick;
  logic             expire;

  loc_tick_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  loc_tick_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sel        (bus_sel),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .expire     (expire),
    .rdata      (bus_rdata),
    .tick_buf   (tick_buf),
    .icnt_buf   (icnt_buf),
    .ctrl       (ctrl),
    .start_load (start_load),
    .icnt_load  (icnt_load),
    .irq        (irq)
  );

  loc_tick_presc #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (ctrl.run),
    .load   (start_load),
    .reload (tick_buf),
    .tick   (tick)
  );

  loc_tick_icnt #(.CNT_W(CNT_W)) u_icnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (tick),
    .active (ctrl.irun),
    .load   (icnt_load),
    .reload (icnt_buf),
    .expire (expire)
  );

  // R10: with the timer stopped the prescaler produces no tick
  p_no_tick_stopped_r10 : assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl.run |-> !tick);

  // R6: expiry only happens while the interrupt counter is running
  p_expire_needs_irun_r6 : assert property (@(posedge clk) disable iff (!rst_n_s)
    expire |-> ctrl.irun);

endmodule

// File: tb/loc_tick_timer_test.sv
module loc_tick_timer_test;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  loc_tick_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    bit        wr;
    bit [7:0]  addr;
    bit [31:0] data;
    bit [31:0] exp;
    bit [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  // Register-level vectors; req holds the requirement number for messages
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,        32'h0, 8'd1},  // R1 tick buffer
    '{1'b0, 8'h08, 32'h0,        32'h0, 8'd1},  // R1 count buffer
    '{1'b0, 8'h20, 32'h0,        32'h0, 8'd1},  // R1 control
    '{1'b0, 8'h30, 32'h0,        32'h0, 8'd1},  // R1 status
    '{1'b0, 8'h34, 32'h0,        32'h0, 8'd1},  // R1 enable
    '{1'b0, 8'h40, 32'h0,        32'h0, 8'd1},  // R1 write-ack
    '{1'b1, 8'h00, 32'h2,        32'h0, 8'd2},  // R2 load T=2
    '{1'b0, 8'h00, 32'h0,        32'h2, 8'd2},
    '{1'b0, 8'h40, 32'h0,        32'h1, 8'd2},
    '{1'b1, 8'h40, 32'h0,        32'h0, 8'd5},  // R5 writing 0 keeps
    '{1'b0, 8'h40, 32'h0,        32'h1, 8'd5},
    '{1'b1, 8'h40, 32'h1,        32'h0, 8'd5},
    '{1'b0, 8'h40, 32'h0,        32'h0, 8'd5},
    '{1'b1, 8'h08, 32'h5,        32'h0, 8'd3},  // R3 no update bit
    '{1'b0, 8'h08, 32'h0,        32'h0, 8'd3},
    '{1'b0, 8'h40, 32'h0,        32'h2, 8'd3},
    '{1'b1, 8'h08, 32'h80000003, 32'h0, 8'd3},  // R3 update, N=3
    '{1'b0, 8'h08, 32'h0,        32'h3, 8'd3},
    '{1'b1, 8'h40, 32'h2,        32'h0, 8'd5},
    '{1'b0, 8'h40, 32'h0,        32'h0, 8'd5},
    '{1'b1, 8'h34, 32'h1,        32'h0, 8'd9},  // R9 enable on
    '{1'b0, 8'h34, 32'h0,        32'h1, 8'd9},
    '{1'b1, 8'h50, 32'hFFFFFFFF, 32'h0, 8'd11}, // R11 unmapped write
    '{1'b0, 8'h50, 32'h0,        32'h0, 8'd11},
    '{1'b0, 8'h40, 32'h0,        32'h0, 8'd11},
    '{1'b0, 8'h3C, 32'h0,        32'h0, 8'd11}
  };

  localparam int T_VAL = 2;
  localparam int N_VAL = 3;
  localparam int PER   = N_VAL * (T_VAL + 1);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Write: applied at the posedge between the two negedges
  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Count edges until irq is seen, starting from the running count
  task automatic wait_irq(inout int cyc, input int limit);
    while (!irq && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1..R11 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    chk("R1", {31'b0, irq}, 32'h0, "irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bwr(VEC[i].addr, VEC[i].data);
      else begin
        brd(VEC[i].addr, rd);
        chk($sformatf("R%0d", VEC[i].req), rd, VEC[i].exp,
            $sformatf("vector %0d offset 0x%0h", i, VEC[i].addr));
      end
    end

    // R6: one-shot expiry timing and stop
    bwr(8'h20, 32'h3);
    cyc = 0; wait_irq(cyc, 100);
    chk("R6", cyc, PER, "one-shot expiry cycle");
    brd(8'h20, rd); chk("R6", rd, 32'h1, "int-run bit cleared");
    brd(8'h40, rd); chk("R4", rd, 32'h8, "control write ack");
    brd(8'h30, rd); chk("R8", rd, 32'h1, "status set");
    bwr(8'h30, 32'h1);
    brd(8'h30, rd); chk("R8", rd, 32'h0, "status W1C");
    cyc = 0; wait_irq(cyc, 4 * PER);
    chk("R6", cyc, 4 * PER, "no second one-shot expiry");

    // R9: masked status does not reach irq
    bwr(8'h34, 32'h0);
    bwr(8'h20, 32'h0);
    bwr(8'h20, 32'h3);
    repeat (PER + 3) @(negedge clk);
    chk("R9", {31'b0, irq}, 32'h0, "irq masked");
    brd(8'h30, rd); chk("R9", rd, 32'h1, "status behind mask");
    bwr(8'h34, 32'h1);
    chk("R9", {31'b0, irq}, 32'h1, "irq unmasked");
    bwr(8'h30, 32'h1);
    chk("R9", {31'b0, irq}, 32'h0, "irq after clear");

    // R7: repeat mode, period kept across a status clear
    bwr(8'h20, 32'h0);
    bwr(8'h20, 32'h7);
    cyc = 0; wait_irq(cyc, 100);
    chk("R7", cyc, PER, "first repeat expiry");
    bwr(8'h30, 32'h1);
    cyc = cyc + 2;
    wait_irq(cyc, 100);
    chk("R7", cyc, 2 * PER, "second repeat expiry");
    bwr(8'h30, 32'h1);

    // R10: stop midway, no expiry while frozen, restart gives full period
    repeat (3) @(negedge clk);
    bwr(8'h20, 32'h6);
    cyc = 0; wait_irq(cyc, 5 * PER);
    chk("R10", cyc, 5 * PER, "no expiry while stopped");
    bwr(8'h20, 32'h7);
    cyc = 0; wait_irq(cyc, 100);
    chk("R10", cyc, PER, "restart reloads both counters");

    // R1: reset while running
    do_reset();
    chk("R1", {31'b0, irq}, 32'h0, "irq after run-time reset");
    brd(8'h20, rd); chk("R1", rd, 32'h0, "control after run-time reset");
    brd(8'h00, rd); chk("R1", rd, 32'h0, "tick buffer after run-time reset");

    summary();
    $finish;
  end

endmodule